// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page table entries. It sits beside an address-generation stage. That stage presents a virtual page number together with the current address-space number and receives, in the same cycle, a hit flag, the slot that matched, and the stored entry. The address-space tag lets mappings from several processes live side by side. An entry with its shared bit set answers for every address space. Each stored entry carries a physical page number, an owning address-space number, the shared bit, a read-enable and a write-enable mask with one bit per processor mode, and two fault-on-access bits. Pages are 8 KB, so the page number is the virtual address with its low 13 bits removed, and the requester supplies it already shifted.

A single command port carries a three-bit opcode. It changes the contents at the next rising clock edge:

- **Idle**: no change.
- **Insert**: writes the slot named by a round-robin victim pointer.
- **Drop-all**: empties the buffer.
- **Drop-private**: removes every entry that is not shared.
- **Drop-page**: removes every entry that would hit for a given page number and address space.
- **Step**: moves the victim pointer without touching the entries.

The slot under the victim pointer is always visible on a side port, so a page-table refill agent can inspect the next victim.

Top module: `asn_tlb`

## Requirements
- R1: `lk_hit` is 1 in the same cycle as the query only when some slot is valid, its stored page number equals `lk_vpn`, and either its shared bit is 1 or its stored address-space number equals `lk_asn`. Otherwise `lk_hit` is 0.
- R2: When several slots match, `lk_idx` names the lowest-numbered one and `lk_pte` returns that slot's entry. The entry layout is: bits 46:19 physical page, 18:11 address-space number, 10 shared, 9:6 read-enable mask, 5:2 write-enable mask, 1 fault-on-read, 0 fault-on-write.
- R3: Opcode 1 (insert) stores `cmd_pte` and the tag `cmd_vpn` into the slot under the victim pointer and marks it valid. Whatever that slot held before is lost.
- R4: After each insert or step, the victim pointer moves to the next slot, wrapping from DEPTH-1 to 0.
- R5: Opcode 2 (drop-all) invalidates every slot and returns the victim pointer to 0.
- R6: Opcode 3 (drop-private) invalidates every slot whose shared bit is 0 and keeps every shared slot.
- R7: Opcode 4 (drop-page) invalidates every slot that would hit for `cmd_vpn` and `cmd_asn`, shared slots included. All other slots are left unchanged.
- R8: `nlu_idx`, `nlu_valid` and `nlu_pte` show the victim pointer and the slot it names. Opcode 5 (step) advances the pointer and leaves every entry unchanged.
- R9: While `rst_n` is low, all slots become invalid and the victim pointer becomes 0.
- R10: Opcode 0 and the unused codes 6 and 7 change neither entries nor pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_vpn | input | 30 | Query virtual page number |
| lk_asn | input | 8 | Current address-space number |
| lk_hit | output | 1 | Query matched a slot |
| lk_idx | output | 6 | Lowest matching slot |
| lk_pte | output | 47 | Entry of the matching slot |
| cmd_op | input | 3 | Command opcode |
| cmd_vpn | input | 30 | Page number for insert or drop-page |
| cmd_asn | input | 8 | Address space for drop-page |
| cmd_pte | input | 47 | Entry written by insert |
| nlu_idx | output | 6 | Victim pointer |
| nlu_valid | output | 1 | Victim slot holds a valid entry |
| nlu_pte | output | 47 | Entry in the victim slot |

## Verification
The lookup path has no register, so `lk_hit`, `lk_idx` and `lk_pte` respond to the query inputs with zero cycles of delay. Every command takes effect at the first rising edge after it is driven, and its effect is visible on both the lookup and the victim ports from that edge onward. The bench therefore drives each command at a falling edge and removes it one time unit after the next rising edge. It then sets up queries and compares outputs a further time unit later, well clear of any edge. Multi-step effects such as pointer wrap are checked only after the exact number of commands that should produce them.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
    parameter int VPN_W = 30;
    parameter int PPN_W = 28;
    parameter int ASN_W = 8;
    parameter int NMODE = 4;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [ASN_W-1:0] asn;
        logic             shared;
        logic [NMODE-1:0] rd_en;
        logic [NMODE-1:0] wr_en;
        logic             fault_rd;
        logic             fault_wr;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_INSERT     = 3'd1,
        OP_DROP_ALL   = 3'd2,
        OP_DROP_PRIV  = 3'd3,
        OP_DROP_PAGE  = 3'd4,
        OP_STEP       = 3'd5,
        OP_RSVD6      = 3'd6,
        OP_RSVD7      = 3'd7
    } tlb_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][VPN_W-1:0] tags,
    input  logic [DEPTH-1:0][ASN_W-1:0] asns,
    input  logic [DEPTH-1:0]            shared,
    input  logic [VPN_W-1:0]            q_vpn,
    input  logic [ASN_W-1:0]            q_asn,
    output logic [DEPTH-1:0]            hits
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign hits[s] = valid[s] && (tags[s] == q_vpn) &&
                         (shared[s] || (asns[s] == q_asn));
    end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int N = 48
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IDX_W = $clog2(N);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign found = |req;
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
    parameter int DEPTH = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     advance,
    output logic [$clog2(DEPTH)-1:0] ptr
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ptr <= '0;
        else if (clear)      ptr <= '0;
        else if (advance)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && ptr == LAST) |=> ptr == '0);

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

    assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ptr == '0);
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VPN_W-1:0]         lk_vpn,
    input  logic [ASN_W-1:0]         lk_asn,
    output logic                     lk_hit,
    output logic [$clog2(DEPTH)-1:0] lk_idx,
    output logic [PTE_W-1:0]         lk_pte,
    input  logic [2:0]               cmd_op,
    input  logic [VPN_W-1:0]         cmd_vpn,
    input  logic [ASN_W-1:0]         cmd_asn,
    input  logic [PTE_W-1:0]         cmd_pte,
    output logic [$clog2(DEPTH)-1:0] nlu_idx,
    output logic                     nlu_valid,
    output logic [PTE_W-1:0]         nlu_pte
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0]            valid_q, valid_d;
    logic [DEPTH-1:0][VPN_W-1:0] tag_q;
    pte_t                        pte_q [DEPTH];
    logic [DEPTH-1:0][ASN_W-1:0] asn_vec;
    logic [DEPTH-1:0]            shared_vec;
    logic [DEPTH-1:0]            lk_match, pg_match;
    logic [IDX_W-1:0]            ptr;
    logic                        ptr_clr, ptr_adv, do_write;
    tlb_op_e                     op;

    assign op = tlb_op_e'(cmd_op);

    for (genvar s = 0; s < DEPTH; s++) begin : g_fields
        assign asn_vec[s]    = pte_q[s].asn;
        assign shared_vec[s] = pte_q[s].shared;
    end

    tlb_match #(.DEPTH(DEPTH)) u_lk_match (
        .valid(valid_q), .tags(tag_q), .asns(asn_vec), .shared(shared_vec),
        .q_vpn(lk_vpn), .q_asn(lk_asn), .hits(lk_match)
    );

    tlb_match #(.DEPTH(DEPTH)) u_pg_match (
        .valid(valid_q), .tags(tag_q), .asns(asn_vec), .shared(shared_vec),
        .q_vpn(cmd_vpn), .q_asn(cmd_asn), .hits(pg_match)
    );

    tlb_first #(.N(DEPTH)) u_first (
        .req(lk_match), .found(lk_hit), .idx(lk_idx)
    );

    tlb_rr_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clear(ptr_clr), .advance(ptr_adv), .ptr(ptr)
    );

    // Command decode: each opcode is one transition of the entry state.
    always_comb begin
        valid_d  = valid_q;
        ptr_clr  = 1'b0;
        ptr_adv  = 1'b0;
        do_write = 1'b0;
        unique case (op)
            OP_INSERT: begin
                valid_d[ptr] = 1'b1;
                do_write     = 1'b1;
                ptr_adv      = 1'b1;
            end
            OP_DROP_ALL: begin
                valid_d = '0;
                ptr_clr = 1'b1;
            end
            OP_DROP_PRIV: valid_d = valid_q & shared_vec;
            OP_DROP_PAGE: valid_d = valid_q & ~pg_match;
            OP_STEP:      ptr_adv = 1'b1;
            default:      valid_d = valid_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (do_write) begin
            tag_q[ptr] <= cmd_vpn;
            pte_q[ptr] <= pte_t'(cmd_pte);
        end
    end

    assign lk_pte    = pte_q[lk_idx];
    assign nlu_idx   = ptr;
    assign nlu_valid = valid_q[ptr];
    assign nlu_pte   = pte_q[ptr];

    assert_hit_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q[lk_idx] && tag_q[lk_idx] == lk_vpn &&
                    (pte_q[lk_idx].shared || pte_q[lk_idx].asn == lk_asn)));

    assert_hit_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_match & ((DEPTH'(1) << lk_idx) - DEPTH'(1))) == '0));

    assert_insert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT) |=> (valid_q[$past(ptr)] && tag_q[$past(ptr)] == $past(cmd_vpn)));

    assert_drop_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DROP_ALL) |=> (valid_q == '0));

    assert_drop_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DROP_PRIV) |=> ((valid_q & ~shared_vec) == '0 &&
                                  valid_q == ($past(valid_q) & shared_vec)));

    assert_drop_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DROP_PAGE) |=> ((valid_q & $past(pg_match)) == '0));

    assert_step_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> (valid_q == $past(valid_q)));

    assert_idle_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE || op == OP_RSVD6 || op == OP_RSVD7) |=>
            (valid_q == $past(valid_q) && ptr == $past(ptr)));
endmodule

// File: tb/asn_tlb_tb_top.sv
`timescale 1ns/1ps
module asn_tlb_tb_top;
    localparam int DEPTH = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] lk_vpn = '0;
    logic [7:0]  lk_asn = '0;
    logic        lk_hit;
    logic [5:0]  lk_idx;
    logic [46:0] lk_pte;
    logic [2:0]  cmd_op = 3'd0;
    logic [29:0] cmd_vpn = '0;
    logic [7:0]  cmd_asn = '0;
    logic [46:0] cmd_pte = '0;
    logic [5:0]  nlu_idx;
    logic        nlu_valid;
    logic [46:0] nlu_pte;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    asn_tlb #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pte(lk_pte),
        .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn), .cmd_pte(cmd_pte),
        .nlu_idx(nlu_idx), .nlu_valid(nlu_valid), .nlu_pte(nlu_pte)
    );

    function automatic logic [46:0] mk(input int ppn, input int asn, input bit shr);
        return {28'(ppn), 8'(asn), shr, 4'b0101, 4'b0011, 1'b0, 1'b1};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] o, input int vpn, input int asn, input logic [46:0] pte);
        @(negedge clk);
        cmd_op = o; cmd_vpn = 30'(vpn); cmd_asn = 8'(asn); cmd_pte = pte;
        @(posedge clk);
        #1 cmd_op = 3'd0;
    endtask

    task automatic look(input string req, input int vpn, input int asn,
                        input bit exp_hit, input int exp_idx, input logic [46:0] exp_pte);
        lk_vpn = 30'(vpn); lk_asn = 8'(asn);
        #1;
        chk({req, " hit"}, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) begin
            chk({req, " idx"}, 64'(lk_idx), 64'(exp_idx));
            chk({req, " pte"}, 64'(lk_pte), 64'(exp_pte));
        end
    endtask

    task automatic t_reset;
        look("R9 reset lookup", 0, 0, 1'b0, 0, '0);
        chk("R9 reset pointer", 64'(nlu_idx), 64'd0);
        chk("R9 reset victim invalid", 64'(nlu_valid), 64'd0);
    endtask

    task automatic t_insert_lookup;
        cmd(3'd1, 'h100, 0, mk('h11, 5, 1'b0));
        look("R1 R3 own asn hit", 'h100, 5, 1'b1, 0, mk('h11, 5, 1'b0));
        look("R1 other asn miss", 'h100, 6, 1'b0, 0, '0);
        look("R1 other page miss", 'h101, 5, 1'b0, 0, '0);
        chk("R4 pointer after insert", 64'(nlu_idx), 64'd1);
        cmd(3'd1, 'h200, 0, mk('h22, 7, 1'b1));
        look("R1 shared any asn", 'h200, 3, 1'b1, 1, mk('h22, 7, 1'b1));
    endtask

    task automatic t_multi;
        cmd(3'd1, 'h100, 0, mk('h33, 5, 1'b0));
        look("R2 lowest of two", 'h100, 5, 1'b1, 0, mk('h11, 5, 1'b0));
    endtask

    task automatic t_drop_page;
        cmd(3'd4, 'h100, 5, '0);
        look("R7 both copies gone", 'h100, 5, 1'b0, 0, '0);
        look("R7 other page kept", 'h200, 0, 1'b1, 1, mk('h22, 7, 1'b1));
        cmd(3'd4, 'h200, 9, '0);
        look("R7 shared page gone", 'h200, 7, 1'b0, 0, '0);
    endtask

    task automatic t_drop_priv;
        cmd(3'd1, 'h300, 0, mk('h44, 1, 1'b0));
        cmd(3'd1, 'h400, 0, mk('h55, 2, 1'b1));
        cmd(3'd3, 0, 0, '0);
        look("R6 private gone", 'h300, 1, 1'b0, 0, '0);
        look("R6 shared kept", 'h400, 2, 1'b1, 4, mk('h55, 2, 1'b1));
        chk("R4 pointer count", 64'(nlu_idx), 64'd5);
    endtask

    task automatic t_idle;
        for (int k = 0; k < 3; k++) cmd(3'd0, 'h400, 0, '0);
        cmd(3'd6, 'h400, 0, mk(1, 1, 1'b0));
        cmd(3'd7, 'h400, 2, '0);
        look("R10 entry kept", 'h400, 2, 1'b1, 4, mk('h55, 2, 1'b1));
        chk("R10 pointer kept", 64'(nlu_idx), 64'd5);
    endtask

    task automatic t_drop_all;
        cmd(3'd2, 0, 0, '0);
        look("R5 all gone", 'h400, 2, 1'b0, 0, '0);
        chk("R5 pointer zero", 64'(nlu_idx), 64'd0);
        chk("R5 victim invalid", 64'(nlu_valid), 64'd0);
    endtask

    task automatic t_step;
        cmd(3'd1, 'h500, 0, mk('h66, 4, 1'b0));
        for (int k = 0; k < DEPTH - 1; k++) cmd(3'd5, 0, 0, '0);
        chk("R8 R4 step wrapped", 64'(nlu_idx), 64'd0);
        chk("R8 victim valid", 64'(nlu_valid), 64'd1);
        chk("R8 victim entry", 64'(nlu_pte), 64'(mk('h66, 4, 1'b0)));
        look("R8 entry kept", 'h500, 4, 1'b1, 0, mk('h66, 4, 1'b0));
    endtask

    task automatic t_wrap;
        cmd(3'd2, 0, 0, '0);
        for (int k = 0; k < DEPTH; k++) cmd(3'd1, 'h1000 + k, 0, mk(k, 3, 1'b0));
        chk("R4 wrap to zero", 64'(nlu_idx), 64'd0);
        look("R3 last slot", 'h1000 + DEPTH - 1, 3, 1'b1, DEPTH - 1, mk(DEPTH - 1, 3, 1'b0));
        cmd(3'd1, 'h2222, 0, mk('h77, 3, 1'b0));
        look("R3 victim replaced", 'h1000, 3, 1'b0, 0, '0);
        look("R3 new entry slot0", 'h2222, 3, 1'b1, 0, mk('h77, 3, 1'b0));
        look("R3 neighbour kept", 'h1001, 3, 1'b1, 1, mk(1, 3, 1'b0));
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_insert_lookup();
        t_multi();
        t_drop_page();
        t_drop_priv();
        t_idle();
        t_drop_all();
        t_step();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule